// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a small fully associative address translation cache. Every entry holds one virtual tag that covers two neighbouring 4 KB pages: an even page and an odd page. Each page has its own frame number, cache attribute, dirty bit and valid bit. A purely combinational lookup port takes a 32-bit virtual address and the current address-space identifier. It returns the physical frame, attribute and dirty bit of the selected page. When no frame can be returned, it says why: either no tag matched (a refill-class miss) or a tag matched but the selected page is marked invalid (an invalid-class fault).

Software manages the block through a small register file and four commands. The registers are a tag register, one word per page half, an index register, a pinned-entry boundary and a free-running victim pointer. The commands are probe, indexed read, indexed write and victim write. The pinned boundary keeps the low-numbered entries out of reach of victim writes, so fixed mappings survive replacement.

Top module: `ptlb_top`

## Requirements
- R1: A lookup hits when an entry's tag (virtual address bits 31:13) equals the address tag and either the entry's space identifier equals the lookup identifier or the entry is global. Address bit 12 selects the half (0 = even word, 1 = odd word). On a hit the frame, attribute and dirty bit of that half appear on the same cycle.
- R2: When no entry's tag matches, `lk_miss` is 1 and `lk_hit` and `lk_inval` are 0.
- R3: When an entry matches but the selected half's valid bit is 0, `lk_inval` is 1 and `lk_hit` and `lk_miss` are 0. Exactly one of the three flags is 1 at any time.
- R4: When several entries match, the lowest-numbered one supplies the result, both for lookups and for probe.
- R5: The stored global flag is the AND of bit 0 of the two page words at write time. An indexed read returns that single flag in bit 0 of both words.
- R6: The page word layout is: bit 0 global, bit 1 valid, bit 2 dirty, bits 5:3 attribute, bits 31:6 frame. The tag register keeps bits 31:13 and the low ID_W bits and reads 0 elsewhere. The index register reads the entry number in its low bits and the probe-fail flag in bit 31; a software write clears the flag. The pinned and victim registers read their entry number in the low bits. An indexed write followed by an indexed read returns the same tag and page words.
- R7: Probe compares the tag register against all entries using the same rule as R1. On a hit it loads the entry number into the index register with bit 31 clear. On no match it sets bit 31.
- R8: The victim pointer steps down by one every cycle from ENTRIES-1 to the pinned value. It then returns to ENTRIES-1. Writing the pinned register sets it to ENTRIES-1 on the same edge.
- R9: A victim write stores the tag and page words into the entry the victim pointer showed on that edge, which is never below the pinned value.
- R10: Rewriting an entry with a different tag makes a lookup of the old address miss in the cycle right after the write.
- R11: After reset all entries and registers are zero and the victim pointer is ENTRIES-1.
- Select codes: 0 tag, 1 even word, 2 odd word, 3 index, 4 pinned, 5 victim. Command codes: 0 probe, 1 indexed read, 2 indexed write, 3 victim write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_va | input | 32 | Virtual address to translate |
| lk_id | input | ID_W | Current address-space identifier |
| lk_hit | output | 1 | Translation found and valid |
| lk_miss | output | 1 | No tag matched (refill class) |
| lk_inval | output | 1 | Tag matched, selected half invalid |
| lk_pfn | output | 26 | Physical frame number (0 unless hit) |
| lk_attr | output | 3 | Cache attribute (0 unless hit) |
| lk_dirty | output | 1 | Dirty bit (0 unless hit) |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register, combinational |
| cmd_go | input | 1 | Command strobe, acts on the next edge |
| cmd_op | input | 2 | Command code |

## Verification
The bench builds the block at its defaults: eight entries and an 8-bit identifier. With eight entries, the victim pointer's whole down-count and wrap against a pinned value of 2 fits in a few cycles, so R8 is checked value by value. The constrained random phase draws tags from a pool of four and identifiers from a pool of three. Duplicate tags, global entries and identifier mismatches therefore occur often, which exercises the lowest-entry priority and the split between miss and invalid.

// File: rtl/ptlb_pkg.sv
// Shared layout constants and types for the paired-page translation buffer.
// Assumes a 32-bit virtual address with 4 KB pages, so one tag covers 8 KB.
package ptlb_pkg;
    localparam int WORD_W     = 32;
    localparam int HALF_BIT   = 12;
    localparam int VPN2_LSB   = 13;
    localparam int VPN2_W     = WORD_W - VPN2_LSB;
    localparam int PFN_LSB    = 6;
    localparam int PFN_W      = WORD_W - PFN_LSB;
    localparam int FAIL_BIT   = WORD_W - 1;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic [2:0]       attr;
        logic             dirty;
        logic             valid;
    } half_t;

    typedef enum logic [1:0] {
        OP_PROBE     = 2'd0,
        OP_READ      = 2'd1,
        OP_WRITE_IDX = 2'd2,
        OP_WRITE_RND = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        SEL_TAG    = 3'd0,
        SEL_EVEN   = 3'd1,
        SEL_ODD    = 3'd2,
        SEL_INDEX  = 3'd3,
        SEL_PIN    = 3'd4,
        SEL_VICTIM = 3'd5
    } sel_e;

    // Split a page word into its stored fields (global bit handled apart).
    function automatic half_t word_to_half(input logic [WORD_W-1:0] w);
        half_t h;
        h.pfn   = w[WORD_W-1:PFN_LSB];
        h.attr  = w[5:3];
        h.dirty = w[2];
        h.valid = w[1];
        return h;
    endfunction

    // Rebuild a page word from stored fields and the shared global flag.
    function automatic logic [WORD_W-1:0] half_to_word(input half_t h, input logic g);
        return {h.pfn, h.attr, h.dirty, h.valid, g};
    endfunction
endpackage

// File: rtl/ptlb_match.sv
// Tag comparator across all entries with lowest-index priority.
// Assumes the table arrays are stable during the cycle; purely combinational.
module ptlb_match
    import ptlb_pkg::*;
#(
    parameter  int ENTRIES = 8,
    parameter  int ID_W    = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [VPN2_W-1:0] vpn2_tab [ENTRIES],
    input  logic [ID_W-1:0]   id_tab   [ENTRIES],
    input  logic              g_tab    [ENTRIES],
    input  logic [VPN2_W-1:0] key_vpn2,
    input  logic [ID_W-1:0]   key_id,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [ENTRIES-1:0] eq;

    // Per-entry comparison: tag equal and (identifier equal or global).
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign eq[e] = (vpn2_tab[e] == key_vpn2) && (g_tab[e] || (id_tab[e] == key_id));
    end

    // Priority pick: scan downward so the lowest matching entry is kept.
    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (eq[e]) hit_idx = IDX_W'(e);
        end
    end
endmodule

// File: rtl/ptlb_victim.sv
// Replacement pointer: counts down from the top entry to the pinned boundary,
// then wraps. Assumes pin_q is the registered boundary; pin_load marks its write.
module ptlb_victim #(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int TOP     = ENTRIES - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_load,
    input  logic [IDX_W-1:0] pin_q,
    output logic [IDX_W-1:0] victim_q
);
    // Step the pointer down, wrapping at the pinned boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || pin_load)  victim_q <= IDX_W'(TOP);
        else if (victim_q <= pin_q) victim_q <= IDX_W'(TOP);
        else                     victim_q <= victim_q - 1'b1;
    end

    // R8
    victim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_load && victim_q > pin_q) |=> victim_q == $past(victim_q) - 1'b1);

    // R8
    victim_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_load || victim_q <= pin_q) |=> victim_q == IDX_W'(TOP));
endmodule

// File: rtl/ptlb_store.sv
// Entry storage: one tag, identifier, global flag and two page halves per entry.
// Assumes at most one write per cycle, addressed by widx.
module ptlb_store
    import ptlb_pkg::*;
#(
    parameter  int ENTRIES = 8,
    parameter  int ID_W    = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [VPN2_W-1:0] w_vpn2,
    input  logic [ID_W-1:0]   w_id,
    input  logic              w_g,
    input  half_t             w_even,
    input  half_t             w_odd,
    output logic [VPN2_W-1:0] vpn2_tab [ENTRIES],
    output logic [ID_W-1:0]   id_tab   [ENTRIES],
    output logic              g_tab    [ENTRIES],
    output half_t             even_tab [ENTRIES],
    output half_t             odd_tab  [ENTRIES]
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        // Clear on reset, replace the whole entry when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn2_tab[e] <= '0;
                id_tab[e]   <= '0;
                g_tab[e]    <= 1'b0;
                even_tab[e] <= '0;
                odd_tab[e]  <= '0;
            end else if (we && widx == IDX_W'(e)) begin
                vpn2_tab[e] <= w_vpn2;
                id_tab[e]   <= w_id;
                g_tab[e]    <= w_g;
                even_tab[e] <= w_even;
                odd_tab[e]  <= w_odd;
            end
        end
    end

    // R6
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (vpn2_tab[$past(widx)] == $past(w_vpn2)) && (odd_tab[$past(widx)] == $past(w_odd)));
endmodule

// File: rtl/ptlb_top.sv
// Paired-page translation buffer: combinational lookup plus a register file
// with probe, indexed read/write and victim write. Assumes ID_W <= 12 and a
// command and a register write never fall in the same cycle (command wins).
module ptlb_top
    import ptlb_pkg::*;
#(
    parameter  int ENTRIES = 8,
    parameter  int ID_W    = 8,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int TOP     = ENTRIES - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       lk_va,
    input  logic [ID_W-1:0]   lk_id,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_inval,
    output logic [25:0]       lk_pfn,
    output logic [2:0]        lk_attr,
    output logic              lk_dirty,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              cmd_go,
    input  logic [1:0]        cmd_op
);
    // Register file state.
    logic [VPN2_W-1:0] tag_vpn2_q;
    logic [ID_W-1:0]   tag_id_q;
    logic [WORD_W-1:0] even_q, odd_q;
    logic [IDX_W-1:0]  idx_q;
    logic              idx_fail_q;
    logic [IDX_W-1:0]  pin_q;
    logic [IDX_W-1:0]  victim_q;

    // Table outputs.
    logic [VPN2_W-1:0] vpn2_tab [ENTRIES];
    logic [ID_W-1:0]   id_tab   [ENTRIES];
    logic              g_tab    [ENTRIES];
    half_t             even_tab [ENTRIES];
    half_t             odd_tab  [ENTRIES];

    op_e  op;
    sel_e sel;
    logic do_probe, do_read, do_write, pin_load;
    logic [IDX_W-1:0] widx;

    assign op       = op_e'(cmd_op);
    assign sel      = sel_e'(cfg_sel);
    assign do_probe = cmd_go && (op == OP_PROBE);
    assign do_read  = cmd_go && (op == OP_READ);
    assign do_write = cmd_go && (op == OP_WRITE_IDX || op == OP_WRITE_RND);
    assign widx     = (op == OP_WRITE_RND) ? victim_q : idx_q;
    assign pin_load = cfg_we && !cmd_go && (sel == SEL_PIN);

    ptlb_store #(.ENTRIES(ENTRIES), .ID_W(ID_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (do_write),
        .widx     (widx),
        .w_vpn2   (tag_vpn2_q),
        .w_id     (tag_id_q),
        .w_g      (even_q[0] & odd_q[0]),
        .w_even   (word_to_half(even_q)),
        .w_odd    (word_to_half(odd_q)),
        .vpn2_tab (vpn2_tab),
        .id_tab   (id_tab),
        .g_tab    (g_tab),
        .even_tab (even_tab),
        .odd_tab  (odd_tab)
    );

    ptlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_load (pin_load),
        .pin_q    (pin_q),
        .victim_q (victim_q)
    );

    // Lookup path.
    logic             lk_match;
    logic [IDX_W-1:0] lk_idx;
    half_t            lk_half;

    ptlb_match #(.ENTRIES(ENTRIES), .ID_W(ID_W)) u_lk_match (
        .vpn2_tab (vpn2_tab),
        .id_tab   (id_tab),
        .g_tab    (g_tab),
        .key_vpn2 (lk_va[WORD_W-1:VPN2_LSB]),
        .key_id   (lk_id),
        .hit      (lk_match),
        .hit_idx  (lk_idx)
    );

    // Probe path, keyed by the tag register.
    logic             pr_match;
    logic [IDX_W-1:0] pr_idx;

    ptlb_match #(.ENTRIES(ENTRIES), .ID_W(ID_W)) u_pr_match (
        .vpn2_tab (vpn2_tab),
        .id_tab   (id_tab),
        .g_tab    (g_tab),
        .key_vpn2 (tag_vpn2_q),
        .key_id   (tag_id_q),
        .hit      (pr_match),
        .hit_idx  (pr_idx)
    );

    // Pick the half by address bit 12 and classify the result.
    always_comb begin
        lk_half  = lk_va[HALF_BIT] ? odd_tab[lk_idx] : even_tab[lk_idx];
        lk_miss  = !lk_match;
        lk_inval = lk_match && !lk_half.valid;
        lk_hit   = lk_match && lk_half.valid;
        lk_pfn   = lk_hit ? lk_half.pfn  : '0;
        lk_attr  = lk_hit ? lk_half.attr : '0;
        lk_dirty = lk_hit && lk_half.dirty;
    end

    // Register file update: commands take priority over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_vpn2_q <= '0;
            tag_id_q   <= '0;
            even_q     <= '0;
            odd_q      <= '0;
            idx_q      <= '0;
            idx_fail_q <= 1'b0;
            pin_q      <= '0;
        end else if (do_probe) begin
            idx_q      <= pr_match ? pr_idx : '0;
            idx_fail_q <= !pr_match;
        end else if (do_read) begin
            tag_vpn2_q <= vpn2_tab[idx_q];
            tag_id_q   <= id_tab[idx_q];
            even_q     <= half_to_word(even_tab[idx_q], g_tab[idx_q]);
            odd_q      <= half_to_word(odd_tab[idx_q], g_tab[idx_q]);
        end else if (cfg_we && !cmd_go) begin
            case (sel)
                SEL_TAG: begin
                    tag_vpn2_q <= cfg_wdata[WORD_W-1:VPN2_LSB];
                    tag_id_q   <= cfg_wdata[ID_W-1:0];
                end
                SEL_EVEN:  even_q <= cfg_wdata;
                SEL_ODD:   odd_q  <= cfg_wdata;
                SEL_INDEX: begin
                    idx_q      <= cfg_wdata[IDX_W-1:0];
                    idx_fail_q <= 1'b0;
                end
                SEL_PIN:   pin_q  <= cfg_wdata[IDX_W-1:0];
                default: ;
            endcase
        end
    end

    // Read-back multiplexer, unused bits zero.
    always_comb begin
        cfg_rdata = '0;
        case (sel)
            SEL_TAG: begin
                cfg_rdata[WORD_W-1:VPN2_LSB] = tag_vpn2_q;
                cfg_rdata[ID_W-1:0]          = tag_id_q;
            end
            SEL_EVEN:   cfg_rdata = even_q;
            SEL_ODD:    cfg_rdata = odd_q;
            SEL_INDEX: begin
                cfg_rdata[FAIL_BIT]  = idx_fail_q;
                cfg_rdata[IDX_W-1:0] = idx_q;
            end
            SEL_PIN:    cfg_rdata[IDX_W-1:0] = pin_q;
            SEL_VICTIM: cfg_rdata[IDX_W-1:0] = victim_q;
            default: ;
        endcase
    end

    // R3
    lk_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({lk_hit, lk_miss, lk_inval}));

    // R7
    probe_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_probe && pr_match) |=> (!idx_fail_q && idx_q == $past(pr_idx)));

    // R7
    probe_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_probe && !pr_match) |=> idx_fail_q);

    // R9
    rnd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && op == OP_WRITE_RND && pin_q <= IDX_W'(TOP)) |-> victim_q >= pin_q);
endmodule

// File: tb/ptlb_top_bench.sv
module ptlb_top_bench;
    localparam int ENTRIES = 8;
    localparam int ID_W    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_id = '0;
    logic        lk_hit, lk_miss, lk_inval, lk_dirty;
    logic [25:0] lk_pfn;
    logic [2:0]  lk_attr;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cmd_go = 1'b0;
    logic [1:0]  cmd_op = '0;

    int nvec = 0;
    int nbad = 0;

    // Bench-side mirror of the table.
    logic [18:0] m_vpn2 [ENTRIES];
    logic [7:0]  m_id   [ENTRIES];
    logic        m_g    [ENTRIES];
    logic [31:0] m_lo0  [ENTRIES];
    logic [31:0] m_lo1  [ENTRIES];

    always #10 clk = ~clk;

    ptlb_top #(.ENTRIES(ENTRIES), .ID_W(ID_W)) u_ptlb_top (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_id(lk_id),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_inval(lk_inval),
        .lk_pfn(lk_pfn), .lk_attr(lk_attr), .lk_dirty(lk_dirty),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cmd_go(cmd_go), .cmd_op(cmd_op)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_lo(input logic [25:0] pfn, input logic [2:0] attr,
                                          input bit d, input bit v, input bit g);
        return {pfn, attr, d, v, g};
    endfunction

    task automatic reg_wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] s, output logic [31:0] d);
        cfg_sel = s;
        #1;
        d = cfg_rdata;
    endtask

    task automatic do_cmd(input logic [1:0] op);
        @(negedge clk);
        cmd_go = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    // Load the three staging registers.
    task automatic stage(input logic [31:0] hi, input logic [31:0] lo0, input logic [31:0] lo1);
        reg_wr(3'd0, hi);
        reg_wr(3'd1, lo0);
        reg_wr(3'd2, lo1);
    endtask

    task automatic mirror(input int k, input logic [31:0] hi, input logic [31:0] lo0, input logic [31:0] lo1);
        m_vpn2[k] = hi[31:13];
        m_id[k]   = hi[7:0];
        m_g[k]    = lo0[0] & lo1[0];
        m_lo0[k]  = lo0;
        m_lo1[k]  = lo1;
    endtask

    task automatic prog(input int k, input logic [31:0] hi, input logic [31:0] lo0, input logic [31:0] lo1);
        stage(hi, lo0, lo1);
        reg_wr(3'd3, k);
        do_cmd(2'd2);
        mirror(k, hi, lo0, lo1);
    endtask

    // Expected lookup result from the requirements (R1..R4).
    task automatic expect_lk(input logic [31:0] va, input logic [7:0] id,
                             output bit h, output bit m, output bit iv,
                             output logic [25:0] pfn, output logic [2:0] attr, output bit d);
        int sel;
        logic [31:0] w;
        sel = -1;
        for (int e = ENTRIES - 1; e >= 0; e--)
            if (m_vpn2[e] == va[31:13] && (m_g[e] || m_id[e] == id)) sel = e;
        h = 0; m = 0; iv = 0; pfn = '0; attr = '0; d = 0;
        if (sel < 0) m = 1;
        else begin
            w = va[12] ? m_lo1[sel] : m_lo0[sel];
            if (!w[1]) iv = 1;
            else begin h = 1; pfn = w[31:6]; attr = w[5:3]; d = w[2]; end
        end
    endtask

    task automatic chk_lk(input logic [31:0] va, input logic [7:0] id, input string req);
        bit h, m, iv, d;
        logic [25:0] pfn;
        logic [2:0] attr;
        bit ok;
        lk_va = va; lk_id = id;
        #1;
        expect_lk(va, id, h, m, iv, pfn, attr, d);
        ok = (lk_hit == h) && (lk_miss == m) && (lk_inval == iv);
        if (h) ok = ok && (lk_pfn == pfn) && (lk_attr == attr) && (lk_dirty == d);
        check(ok, req, $sformatf("lookup va=%h id=%h {hit,miss,inval,pfn}", va, id),
              {lk_hit, lk_miss, lk_inval, 3'b0, lk_pfn}, {h, m, iv, 3'b0, pfn});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin : main
        logic [31:0] r, r2;
        int v, exp_v;
        void'($urandom(32'd4242));
        for (int e = 0; e < ENTRIES; e++) mirror(e, '0, '0, '0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        reg_rd(3'd5, r);  check(r == 32'd7, "R11", "victim after reset", r, 32'd7);
        reg_rd(3'd0, r);  check(r == 0, "R11", "tag after reset", r, 0);
        reg_rd(3'd3, r);  check(r == 0, "R11", "index after reset", r, 0);
        reg_rd(3'd4, r);  check(r == 0, "R11", "pinned after reset", r, 0);
        chk_lk(32'h0000_0000, 8'h00, "R11");

        // R6: register field formats
        reg_wr(3'd0, 32'hFFFF_FFFF);
        reg_rd(3'd0, r);  check(r == 32'hFFFF_E0FF, "R6", "tag unused bits", r, 32'hFFFF_E0FF);
        reg_wr(3'd3, 32'hFFFF_FFFD);
        reg_rd(3'd3, r);  check(r == 32'd5, "R6", "index write format", r, 32'd5);

        // R1/R3: one entry, even valid, odd invalid
        prog(0, 32'h0001_2001, mk_lo(26'h00091, 3'd3, 1, 1, 0), mk_lo(26'h000C1, 3'd2, 0, 0, 0));
        chk_lk(32'h0001_2abc, 8'h01, "R1");
        chk_lk(32'h0001_3abc, 8'h01, "R3");
        // R2: identifier mismatch, non-global
        chk_lk(32'h0001_2abc, 8'h02, "R2");
        chk_lk(32'h0005_0000, 8'h01, "R2");

        // R5: global only when both words carry it
        prog(1, 32'h0002_4005, mk_lo(26'h00100, 3'd1, 0, 1, 1), mk_lo(26'h00140, 3'd7, 1, 1, 1));
        chk_lk(32'h0002_5000, 8'h33, "R5");
        prog(2, 32'h0003_6005, mk_lo(26'h00191, 3'd1, 0, 1, 1), mk_lo(26'h001D3, 3'd7, 1, 1, 0));
        chk_lk(32'h0003_6000, 8'h33, "R5");
        reg_wr(3'd3, 2);
        stage('0, '0, '0);
        do_cmd(2'd1);
        reg_rd(3'd1, r);  check(r == mk_lo(26'h00191, 3'd1, 0, 1, 0), "R5", "even word global", r, mk_lo(26'h00191, 3'd1, 0, 1, 0));
        reg_rd(3'd2, r);  check(r == mk_lo(26'h001D3, 3'd7, 1, 1, 0), "R5", "odd word global", r, mk_lo(26'h001D3, 3'd7, 1, 1, 0));
        reg_rd(3'd0, r);  check(r == 32'h0003_6005, "R6", "tag read-back", r, 32'h0003_6005);

        // R4: duplicate global tags in entries 3 and 5
        prog(5, 32'h0004_8000, mk_lo(26'h00555, 3'd0, 0, 1, 1), mk_lo(26'h00556, 3'd0, 0, 1, 1));
        prog(3, 32'h0004_8000, mk_lo(26'h00333, 3'd0, 0, 1, 1), mk_lo(26'h00334, 3'd0, 0, 1, 1));
        chk_lk(32'h0004_9000, 8'h77, "R4");
        reg_wr(3'd0, 32'h0004_8009);
        do_cmd(2'd0);
        reg_rd(3'd3, r);  check(r == 32'd3, "R4", "probe picks lowest", r, 32'd3);
        // R7: probe hit on entry 0, then probe miss
        reg_wr(3'd0, 32'h0001_2001);
        do_cmd(2'd0);
        reg_rd(3'd3, r);  check(r == 32'd0, "R7", "probe hit index", r, 32'd0);
        reg_wr(3'd0, 32'h0001_2002);
        do_cmd(2'd0);
        reg_rd(3'd3, r);  check(r[31] == 1'b1, "R7", "probe miss flag", r, 32'h8000_0000);

        // R10: retag entry 0, old address must miss at once
        stage(32'h0006_6001, mk_lo(26'h00777, 3'd0, 0, 1, 0), mk_lo(26'h00778, 3'd0, 0, 1, 0));
        reg_wr(3'd3, 0);
        @(negedge clk);
        cmd_go = 1'b1; cmd_op = 2'd2;
        @(negedge clk);
        cmd_go = 1'b0;
        mirror(0, 32'h0006_6001, mk_lo(26'h00777, 3'd0, 0, 1, 0), mk_lo(26'h00778, 3'd0, 0, 1, 0));
        chk_lk(32'h0001_2000, 8'h01, "R10");
        chk_lk(32'h0006_6000, 8'h01, "R10");

        // R8: victim sequence with pinned = 2
        reg_wr(3'd4, 2);
        exp_v = 7;
        for (int i = 0; i < 9; i++) begin
            reg_rd(3'd5, r);
            check(r == exp_v, "R8", "victim step", r, exp_v);
            exp_v = (exp_v <= 2) ? 7 : exp_v - 1;
            @(negedge clk);
        end

        // R9: victim writes land on the sampled pointer, never below 2
        for (int i = 0; i < 6; i++) begin
            logic [31:0] hi;
            hi = {19'h70000 + 19'(i), 13'h0};
            stage(hi, mk_lo(26'(i + 9), 3'd1, 0, 1, 1), mk_lo(26'(i + 17), 3'd1, 0, 1, 1));
            repeat ($urandom % 5) @(negedge clk);
            @(negedge clk);
            cfg_sel = 3'd5;
            #1;
            v = int'(cfg_rdata);
            cmd_go = 1'b1; cmd_op = 2'd3;
            @(negedge clk);
            cmd_go = 1'b0;
            mirror(v, hi, mk_lo(26'(i + 9), 3'd1, 0, 1, 1), mk_lo(26'(i + 17), 3'd1, 0, 1, 1));
            check(v >= 2, "R9", "victim above pinned", v, 2);
            do_cmd(2'd0);
            reg_rd(3'd3, r);
            check(r == v, "R9", "probe finds victim-written entry", r, v);
        end
        reg_rd(3'd4, r);  check(r == 2, "R6", "pinned read-back", r, 2);

        // Random phase: small tag and identifier pools
        for (int round = 0; round < 4; round++) begin
            for (int e = 0; e < ENTRIES; e++) begin
                logic [31:0] hi, lo0, lo1;
                hi  = {19'h00100 + 19'($urandom % 4), 5'h0, 8'($urandom % 3)};
                lo0 = $urandom;
                lo1 = $urandom;
                if ($urandom % 3 == 0) begin lo0[0] = 1; lo1[0] = 1; end
                prog(e, hi, lo0, lo1);
                reg_wr(3'd3, e);
                do_cmd(2'd1);
                reg_rd(3'd1, r);
                reg_rd(3'd2, r2);
                check(r == {lo0[31:1], m_g[e]} && r2 == {lo1[31:1], m_g[e]}, "R6",
                      "indexed read-back", r, {lo0[31:1], m_g[e]});
            end
            for (int n = 0; n < 100; n++) begin
                logic [31:0] va;
                va = {19'h00100 + 19'($urandom % 5), 13'($urandom)};
                chk_lk(va, 8'($urandom % 3), "R1");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule